// File: doc/BRIEF.md
# AC97 Receive Slot Validator

This block listens to the serial input side of an AC97 link and decides, frame by frame, whether the data in the frame may be kept. It recovers frame timing from the bit clock and the frame sync line. It collects the tag slot and the twelve following slots. It then compares the per-slot valid flags that the codec places in the tag against a mask supplied by the surrounding controller.

When the flags equal the mask, the upper sixteen bits of every flagged slot are handed to an external receive FIFO, one word per clock, lowest slot first. When any flag differs from the mask, a sticky unexpected-slot flag is raised and the frame's data is thrown away. A frame that flags none of slots 3 to 12 passes without effect: this covers an empty frame and a frame that carries only status.

The block runs on a fast system clock and treats the link lines as asynchronous inputs. The FIFO is never written while it reports full. A word that meets a full FIFO is lost, and a sticky overflow flag records the loss.

Top module: `ac97_rx_validator`

## Requirements
- R1: Link lines are synchronised and sampled at each falling edge of `bit_clk`. A frame begins at the first sample with `sync_in` high after a sample with it low, and that bit is the tag's MSB. Bits arrive MSB first: a 16-bit tag, then slots 1 to 12 of 20 bits each, 256 bits in all.
- R2: The tag bits 12 down to 3 flag slots 3 up to 12. `rx_mask[9]` stands for slot 3 and `rx_mask[0]` for slot 12, so the mask is compared bit for bit with tag bits [12:3].
- R3: When enabled, with the flags non-zero and equal to the mask, the block writes bits [19:4] of each flagged slot to the FIFO. It writes one word per clock in ascending slot order, starting after the frame's last bit.
- R4: When enabled, with the flags non-zero and different from the mask, `unexp_flag` is set and no word of that frame is written.
- R5: A frame whose tag bits [12:3] are all zero writes nothing and leaves `unexp_flag` unchanged, whatever the mask.
- R6: `unexp_flag` stays set until a cycle with `unexp_clr` high clears it.
- R7: While `fifo_full` is high, `fifo_wr_en` stays low. A word due in that cycle is dropped and `ovf_flag` is set, and it stays set until `ovf_clr` is pulsed.
- R8: With `ac97_en` low at the end of a frame, the frame causes no write and no flag change.
- R9: After reset, `fifo_wr_en`, `unexp_flag` and `ovf_flag` are low.
- R10: A new frame start that arrives before 256 bits have been collected abandons the partial frame. Only the new frame is judged.
- R11: Bits that follow a complete frame, with `sync_in` low, are ignored until the next frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ac97_en | input | 1 | Enables judging of received frames |
| rx_mask | input | 10 | Expected data-slot flags, bit 9 = slot 3 |
| bit_clk | input | 1 | Link bit clock, asynchronous |
| sync_in | input | 1 | Link frame sync, asynchronous |
| sdata_in | input | 1 | Link serial data from codec, asynchronous |
| fifo_full | input | 1 | Receive FIFO cannot accept a word |
| fifo_wr_en | output | 1 | FIFO write strobe |
| fifo_wr_data | output | 16 | Word written to the FIFO |
| unexp_clr | input | 1 | Clears the unexpected-slot flag |
| unexp_flag | output | 1 | Sticky unexpected-slot flag |
| ovf_clr | input | 1 | Clears the overflow flag |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
Frames are driven with all ten slots flagged and with a sparse scattered pattern, each equal to its mask. These show that the slot-to-mask bit order and the ascending write order are right. Frames that differ from the mask by a single flag, and frames with no flags under a non-zero mask, separate a real mismatch from an exempt empty or status-only frame. Further frames are driven with the enable low, with the FIFO full, cut short by an early sync, and followed by trailing noise. These show that each condition suppresses exactly the effect it should and nothing more.

// File: rtl/ac97_rx_pkg.sv
package ac97_rx_pkg;
  localparam int TAG_W      = 16;
  localparam int SLOT_W     = 20;
  localparam int WORD_W     = 16;
  localparam int N_DATA     = 10;
  localparam int FIRST_DATA = 3;
  localparam int LAST_SLOT  = 12;
  localparam int FLAG_HI    = 12;

  typedef enum logic {
    DS_IDLE = 1'b0,
    DS_RUN  = 1'b1
  } deser_st_e;
endpackage

// File: rtl/ac97_rx_front.sv
module ac97_rx_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_clk,
  input  logic sync_in,
  input  logic sdata_in,
  output logic bit_stb,
  output logic bit_val,
  output logic frm_start
);
  localparam int NLINES  = 3;
  localparam int L_BCLK  = 2;
  localparam int L_SYNC  = 1;
  localparam int L_SDIN  = 0;

  logic [NLINES-1:0]                  raw;
  logic [SYNC_STAGES-1:0][NLINES-1:0] stage_q;
  logic [NLINES-1:0]                  line_s;
  logic bclk_prev_q, sync_prev_q;
  logic fall, sync_prev_d, stb_d, val_d, start_d;
  logic stb_q, val_q, start_q;

  assign raw = {bit_clk, sync_in, sdata_in};

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= raw;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= {stage_q[SYNC_STAGES-2:0], raw};
      end
    end
  endgenerate

  assign line_s = stage_q[SYNC_STAGES-1];

  always_comb begin
    fall        = bclk_prev_q & ~line_s[L_BCLK];
    stb_d       = fall;
    val_d       = fall ? line_s[L_SDIN] : val_q;
    start_d     = fall & line_s[L_SYNC] & ~sync_prev_q;
    sync_prev_d = fall ? line_s[L_SYNC] : sync_prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_prev_q <= 1'b0;
      sync_prev_q <= 1'b0;
      stb_q       <= 1'b0;
      val_q       <= 1'b0;
      start_q     <= 1'b0;
    end else begin
      bclk_prev_q <= line_s[L_BCLK];
      sync_prev_q <= sync_prev_d;
      stb_q       <= stb_d;
      val_q       <= val_d;
      start_q     <= start_d;
    end
  end

  assign bit_stb   = stb_q;
  assign bit_val   = val_q;
  assign frm_start = start_q;

  AST_STB_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    bit_stb |=> !bit_stb); // R1
  AST_START_ON_STB: assert property (@(posedge clk) disable iff (!rst_n)
    frm_start |-> bit_stb); // R1
endmodule

// File: rtl/ac97_rx_deser.sv
module ac97_rx_deser
  import ac97_rx_pkg::*;
#(
  parameter int N_SLOTS = N_DATA,
  parameter int WW      = WORD_W
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          bit_stb,
  input  logic                          bit_val,
  input  logic                          frm_start,
  output logic                          frame_done,
  output logic [N_SLOTS-1:0]            flags,
  output logic [N_SLOTS-1:0][WW-1:0]    data
);
  localparam int CNT_W  = $clog2(SLOT_W + 1);
  localparam int IDX_W  = $clog2(LAST_SLOT + 1);
  localparam int FLAG_LO = FLAG_HI - N_SLOTS + 1;

  deser_st_e              st_q, st_d;
  logic [IDX_W-1:0]       idx_q, idx_d;
  logic [CNT_W-1:0]       pos_q, pos_d;
  logic [SLOT_W-1:0]      sh_q, sh_d;
  logic [SLOT_W-1:0]      word;
  logic                   last_bit, done_d, done_q;
  logic                   tag_en;
  logic [N_SLOTS-1:0]     flags_q;

  always_comb begin
    word     = {sh_q[SLOT_W-2:0], bit_val};
    last_bit = (idx_q == '0) ? (pos_q == CNT_W'(TAG_W - 1))
                             : (pos_q == CNT_W'(SLOT_W - 1));
    st_d     = st_q;
    idx_d    = idx_q;
    pos_d    = pos_q;
    sh_d     = sh_q;
    done_d   = 1'b0;
    tag_en   = 1'b0;
    if (frm_start) begin
      st_d  = DS_RUN;
      idx_d = '0;
      pos_d = CNT_W'(1);
      sh_d  = {{(SLOT_W-1){1'b0}}, bit_val};
    end else if (bit_stb && st_q == DS_RUN) begin
      sh_d = word;
      if (last_bit) begin
        pos_d  = '0;
        tag_en = (idx_q == '0);
        if (idx_q == IDX_W'(LAST_SLOT)) begin
          st_d   = DS_IDLE;
          done_d = 1'b1;
        end else begin
          idx_d = idx_q + IDX_W'(1);
        end
      end else begin
        pos_d = pos_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= DS_IDLE;
      idx_q  <= '0;
      pos_q  <= '0;
      sh_q   <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      pos_q  <= pos_d;
      sh_q   <= sh_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flags_q <= '0;
    else if (tag_en) flags_q <= word[FLAG_HI:FLAG_LO];
  end

  genvar j;
  generate
    for (j = 0; j < N_SLOTS; j++) begin : g_slot
      logic        cap_en;
      logic [WW-1:0] slot_q;
      assign cap_en = bit_stb && (st_q == DS_RUN) && !frm_start && last_bit &&
                      (idx_q == IDX_W'(FIRST_DATA + j));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      slot_q <= '0;
        else if (cap_en) slot_q <= word[SLOT_W-1 -: WW];
      end
      assign data[j] = slot_q;
    end
  endgenerate

  assign frame_done = done_q;
  assign flags      = flags_q;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done); // R1
  AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= IDX_W'(LAST_SLOT)); // R1
  AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> st_q == DS_IDLE); // R11
endmodule

// File: rtl/ac97_rx_check.sv
module ac97_rx_check
  import ac97_rx_pkg::*;
#(
  parameter int N_SLOTS = N_DATA,
  parameter int WW      = WORD_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       frame_done,
  input  logic [N_SLOTS-1:0]         flags,
  input  logic [N_SLOTS-1:0][WW-1:0] data,
  input  logic                       ac97_en,
  input  logic [N_SLOTS-1:0]         rx_mask,
  input  logic                       fifo_full,
  input  logic                       unexp_clr,
  input  logic                       ovf_clr,
  output logic                       fifo_wr_en,
  output logic [WW-1:0]              fifo_wr_data,
  output logic                       unexp_flag,
  output logic                       ovf_flag
);
  localparam int SEL_W = $clog2(N_SLOTS);

  logic [N_SLOTS-1:0] pend_q, pend_d, pend_load, pend_clr;
  logic [SEL_W-1:0]   sel;
  logic               busy, judge, accept, mismatch, drop;
  logic               unexp_q, unexp_d, ovf_q, ovf_d;

  genvar j;
  generate
    for (j = 0; j < N_SLOTS; j++) begin : g_rev
      assign pend_load[j] = flags[N_SLOTS-1-j];
    end
  endgenerate

  always_comb begin
    sel = '0;
    for (int k = N_SLOTS - 1; k >= 0; k--) begin
      if (pend_q[k]) sel = SEL_W'(k);
    end
  end

  always_comb begin
    busy     = |pend_q;
    judge    = frame_done & ac97_en & (|flags);
    accept   = judge & (flags == rx_mask);
    mismatch = judge & (flags != rx_mask);
    drop     = busy & fifo_full;
    pend_clr = busy ? (N_SLOTS'(1) << sel) : '0;
    pend_d   = accept ? pend_load : (pend_q & ~pend_clr);
    unexp_d  = mismatch | (unexp_q & ~unexp_clr);
    ovf_d    = drop | (ovf_q & ~ovf_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      unexp_q <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      pend_q  <= pend_d;
      unexp_q <= unexp_d;
      ovf_q   <= ovf_d;
    end
  end

  assign fifo_wr_en   = busy & ~fifo_full;
  assign fifo_wr_data = data[sel];
  assign unexp_flag   = unexp_q;
  assign ovf_flag     = ovf_q;

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> pend_q == '0); // R3
  AST_MISMATCH_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && flags != rx_mask) |=> !fifo_wr_en); // R4
  AST_EMPTY_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && flags == '0 && !unexp_clr) |=> unexp_flag == $past(unexp_flag)); // R5
  AST_UNEXP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (unexp_flag && !unexp_clr) |=> unexp_flag); // R6
  AST_DROP_SETS_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && fifo_full) |=> ovf_flag); // R7
  AST_OVF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !ovf_clr) |=> ovf_flag); // R7
  AST_OFF_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !ac97_en) |=> !fifo_wr_en); // R8
endmodule

// File: rtl/ac97_rx_validator.sv
module ac97_rx_validator
  import ac97_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int N_SLOTS     = N_DATA,
  parameter int WW          = WORD_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ac97_en,
  input  logic [N_SLOTS-1:0] rx_mask,
  input  logic               bit_clk,
  input  logic               sync_in,
  input  logic               sdata_in,
  input  logic               fifo_full,
  output logic               fifo_wr_en,
  output logic [WW-1:0]      fifo_wr_data,
  input  logic               unexp_clr,
  output logic               unexp_flag,
  input  logic               ovf_clr,
  output logic               ovf_flag
);
  logic                       bit_stb, bit_val, frm_start, frame_done;
  logic [N_SLOTS-1:0]         flags;
  logic [N_SLOTS-1:0][WW-1:0] data;

  ac97_rx_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk(clk), .rst_n(rst_n), .bit_clk(bit_clk), .sync_in(sync_in),
    .sdata_in(sdata_in), .bit_stb(bit_stb), .bit_val(bit_val),
    .frm_start(frm_start)
  );

  ac97_rx_deser #(.N_SLOTS(N_SLOTS), .WW(WW)) u_deser (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .bit_val(bit_val),
    .frm_start(frm_start), .frame_done(frame_done), .flags(flags),
    .data(data)
  );

  ac97_rx_check #(.N_SLOTS(N_SLOTS), .WW(WW)) u_check (
    .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .flags(flags),
    .data(data), .ac97_en(ac97_en), .rx_mask(rx_mask),
    .fifo_full(fifo_full), .unexp_clr(unexp_clr), .ovf_clr(ovf_clr),
    .fifo_wr_en(fifo_wr_en), .fifo_wr_data(fifo_wr_data),
    .unexp_flag(unexp_flag), .ovf_flag(ovf_flag)
  );

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !fifo_wr_en); // R9
endmodule

// File: tb/ac97_rx_validator_tb.sv
`timescale 1ns/1ps
module ac97_rx_validator_tb;
  logic clk = 1'b0;
  logic rst_n;
  logic ac97_en, bit_clk, sync_in, sdata_in, fifo_full, unexp_clr, ovf_clr;
  logic [9:0]  rx_mask;
  logic        fifo_wr_en, unexp_flag, ovf_flag;
  logic [15:0] fifo_wr_data;

  always #4 clk = ~clk;

  ac97_rx_validator u_dut (
    .clk(clk), .rst_n(rst_n), .ac97_en(ac97_en), .rx_mask(rx_mask),
    .bit_clk(bit_clk), .sync_in(sync_in), .sdata_in(sdata_in),
    .fifo_full(fifo_full), .fifo_wr_en(fifo_wr_en), .fifo_wr_data(fifo_wr_data),
    .unexp_clr(unexp_clr), .unexp_flag(unexp_flag), .ovf_clr(ovf_clr),
    .ovf_flag(ovf_flag)
  );

  int checks = 0;
  int errors = 0;
  logic [15:0] exp_q [$];
  bit exp_unexp = 0;
  bit exp_ovf = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
    end
  endtask

  // reference monitor: every clock, writes must match the expected queue in order
  always @(negedge clk) begin
    if (rst_n === 1'b1 && fifo_wr_en === 1'b1) begin
      chk(fifo_full == 1'b0, "R7 write while full", 32'(fifo_full), 0);
      if (exp_q.size() == 0) begin
        chk(1'b0, "R3 unexpected write", 32'(fifo_wr_data), 0);
      end else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        chk(fifo_wr_data == e, "R3 word/order", 32'(fifo_wr_data), 32'(e));
      end
    end
  end

  task automatic send_bit(input logic s, input logic d);
    bit_clk  = 1'b1;
    sync_in  = s;
    sdata_in = d;
    tick(4);
    bit_clk = 1'b0;
    tick(4);
  endtask

  function automatic logic [255:0] build(input logic [15:0] tag, input logic [12:1][19:0] sl);
    logic [255:0] f;
    f[255:240] = tag;
    for (int k = 1; k <= 12; k++) f[239 - 20*(k-1) -: 20] = sl[k];
    return f;
  endfunction

  task automatic send_bits(input logic [255:0] f, input int nbits);
    for (int b = 0; b < nbits; b++) send_bit(b < 16, f[255 - b]);
  endtask

  task automatic idle_bits(input int n);
    for (int b = 0; b < n; b++) send_bit(1'b0, 1'($urandom));
  endtask

  task automatic model(input logic [15:0] tag, input logic [12:1][19:0] sl);
    logic [9:0] v;
    v = tag[12:3];
    if (!ac97_en || v == 0) return;
    if (v != rx_mask) begin
      exp_unexp = 1;
      return;
    end
    for (int j = 0; j < 10; j++) begin
      if (v[9-j]) begin
        if (fifo_full) exp_ovf = 1;
        else exp_q.push_back(sl[3+j][19:4]);
      end
    end
  endtask

  task automatic frame(input logic [15:0] tag);
    logic [12:1][19:0] sl;
    for (int k = 1; k <= 12; k++) sl[k] = 20'($urandom);
    model(tag, sl);
    send_bits(build(tag, sl), 256);
    idle_bits(6);
  endtask

  task automatic end_check(input string req);
    chk(exp_q.size() == 0, {req, " words outstanding"}, 32'(exp_q.size()), 0);
    chk(unexp_flag == exp_unexp, {req, " unexp_flag"}, 32'(unexp_flag), 32'(exp_unexp));
    chk(ovf_flag == exp_ovf, {req, " ovf_flag"}, 32'(ovf_flag), 32'(exp_ovf));
  endtask

  task automatic clr_unexp();
    unexp_clr = 1'b1;
    tick(1);
    unexp_clr = 1'b0;
    exp_unexp = 0;
    tick(1);
  endtask

  task automatic clr_ovf();
    ovf_clr = 1'b1;
    tick(1);
    ovf_clr = 1'b0;
    exp_ovf = 0;
    tick(1);
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ac97_en = 1'b0; rx_mask = '0; bit_clk = 1'b0; sync_in = 1'b0;
    sdata_in = 1'b0; fifo_full = 1'b0; unexp_clr = 1'b0; ovf_clr = 1'b0;
    tick(5);
    rst_n = 1'b1;
    tick(3);
    // R9 reset state
    chk(fifo_wr_en == 0, "R9 wr_en", 32'(fifo_wr_en), 0);
    chk(unexp_flag == 0, "R9 unexp", 32'(unexp_flag), 0);
    chk(ovf_flag == 0, "R9 ovf", 32'(ovf_flag), 0);

    ac97_en = 1'b1;
    // R1 R2 R3 all slots flagged
    rx_mask = 10'h3FF;
    frame(16'hFFF8);
    end_check("R3 all slots");
    // R2 R3 sparse pattern: slots 3,5,11,12
    rx_mask = 10'b1010000011;
    frame({3'b111, 10'b1010000011, 3'b000});
    end_check("R2 sparse");
    // R4 mismatch by one flag
    frame({3'b100, 10'b1010000001, 3'b000});
    end_check("R4 mismatch");
    // R6 still set after a good frame
    frame({3'b100, 10'b1010000011, 3'b000});
    end_check("R6 sticky");
    clr_unexp();
    end_check("R6 cleared");
    // R5 status-only frame and empty frame
    frame({3'b111, 10'b0, 3'b000});
    end_check("R5 status only");
    frame(16'h0000);
    end_check("R5 empty");
    // R8 disabled: mismatch and match both ignored
    ac97_en = 1'b0;
    frame({3'b100, 10'b0000000001, 3'b000});
    end_check("R8 mismatch off");
    frame({3'b100, 10'b1010000011, 3'b000});
    end_check("R8 match off");
    ac97_en = 1'b1;
    // R7 full FIFO drops and flags
    fifo_full = 1'b1;
    frame({3'b100, 10'b1010000011, 3'b000});
    fifo_full = 1'b0;
    end_check("R7 overflow");
    clr_ovf();
    end_check("R7 cleared");
    // R10 truncated mismatching frame then good frame
    begin
      logic [12:1][19:0] sl;
      for (int k = 1; k <= 12; k++) sl[k] = 20'($urandom);
      send_bits(build({3'b100, 10'b0111111111, 3'b000}, sl), 200);
      frame({3'b100, 10'b1010000011, 3'b000});
      end_check("R10 restart");
    end
    // R11 long trailing noise then one more frame
    idle_bits(300);
    end_check("R11 trailing");
    rx_mask = 10'b0100000100;
    frame({3'b100, 10'b0100000100, 3'b000});
    end_check("R3 second sparse");
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule